// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block takes one fast system clock and builds a family of digitally modelled clocks from it. A CPU-rate clock is formed by toggling every `CPU_HALF` system cycles, and a PCI-rate clock is derived from that CPU clock by a selectable ratio of 2, 3 or 4. Each domain drives two output groups. The gated group can be halted by an active-low stop request. The free group ignores that request.

The two stop requests may change at any time relative to the system clock. Each one passes through a two-stage synchronizer before it acts. Every output also has its own enable bit, which can silence that output on its own. Enable and stop decisions take effect only while the output's clock is low. As a result, a stopped output always rests at 0, and on restart its first high phase has full width.

A global high-impedance request overrides everything at once. It forces all clock outputs to 0 and drops a separate drive-enable flag, which a pad ring would use to float the pins.

Top module: `clkstop_ctrl`

## Requirements
- R1: While reset is asserted, every clock output is 0. In the first system cycle after reset is released, every clock output is still 0.
- R2: The CPU-rate clock has a period of 2*CPU_HALF system cycles, and it is high for CPU_HALF of them.
- R3: The PCI ratio N is chosen by `pci_div_sel`: value 0 gives N=2, value 1 gives N=3, and values 2 and 3 give N=4. The PCI clock has a period of N CPU periods and is high for floor(N/2) CPU periods. Both of its edges coincide with CPU rising edges.
- R4: Each stop input passes through two system-clock flip-flops before it can influence any output.
- R5: After `cpu_stop_n` goes low, every CPU gated output is at rest low within 4 CPU periods. After `cpu_stop_n` returns high, those outputs rise again within 4 CPU periods.
- R6: Every output high pulse has full width: CPU_HALF system cycles in the CPU domain and floor(N/2)*2*CPU_HALF system cycles in the PCI domain. A gated output rises only together with its domain clock.
- R7: After `pci_stop_n` goes low, the PCI gated outputs are at rest low within one PCI period plus 3 system cycles. After `pci_stop_n` returns high, their first rise comes within the same bound.
- R8: Free outputs keep toggling under either stop. Asserting one stop input leaves the gated outputs of the other domain running.
- R9: An enable bit of 0 holds its output at 0, and this applies to free outputs as well. Enable changes are applied only during a low phase, so re-enabling yields a full first pulse.
- R10: While `hiz_i` is 1, all clock outputs are 0 and `drv_en_o` is 0. While `hiz_i` is 0, `drv_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Asynchronous stop request for CPU gated outputs, active low |
| pci_stop_n | input | 1 | Asynchronous stop request for PCI gated outputs, active low |
| pci_div_sel | input | 2 | PCI ratio select (0:/2, 1:/3, 2 or 3:/4) |
| en_cg | input | NCG | Enables for CPU gated outputs |
| en_cf | input | NCF | Enables for CPU free outputs |
| en_pg | input | NPG | Enables for PCI gated outputs |
| en_pf | input | NPF | Enables for PCI free outputs |
| hiz_i | input | 1 | Global high-impedance request |
| cpu_gated_o | output | NCG | CPU-rate outputs stopped by cpu_stop_n |
| cpu_free_o | output | NCF | CPU-rate outputs immune to stops |
| pci_gated_o | output | NPG | PCI-rate outputs stopped by pci_stop_n |
| pci_free_o | output | NPF | PCI-rate outputs immune to stops |
| drv_en_o | output | 1 | Pad drive enable, low while floating |

## Verification
The bench checks stop assertion and release at arbitrary phases. A gate that updated during a high phase would produce a runt pulse, and a per-cycle comparison against a behavioural model catches it as a shortened high run. It measures latency from each stop edge to rest and to the first rise, which exposes a missing or extra synchronizer stage or a stop routed to the wrong domain. It also sweeps every ratio select, including the value 3 that aliases /4, and checks that enable bits silence the free outputs too. A design that applied enables only to gated outputs, or that miscounted the /3 duty, would show a wrong level on those samples.

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int CPU_HALF = 2,
  parameter int NCG = 6,
  parameter int NCF = 3,
  parameter int NPG = 5,
  parameter int NPF = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_stop_n,
  input  logic           pci_stop_n,
  input  logic [1:0]     pci_div_sel,
  input  logic [NCG-1:0] en_cg,
  input  logic [NCF-1:0] en_cf,
  input  logic [NPG-1:0] en_pg,
  input  logic [NPF-1:0] en_pf,
  input  logic           hiz_i,
  output logic [NCG-1:0] cpu_gated_o,
  output logic [NCF-1:0] cpu_free_o,
  output logic [NPG-1:0] pci_gated_o,
  output logic [NPF-1:0] pci_free_o,
  output logic           drv_en_o
);
  localparam int CW = $clog2(CPU_HALF) + 1;

  logic [CW-1:0]  div_cnt;
  logic           cpu_raw, pci_raw;
  logic [1:0]     pci_cnt, pci_cnt_nxt;
  logic [2:0]     ratio, hi_lim;
  logic [1:0]     cs_sync, ps_sync;
  logic [NCG-1:0] ecg_q;
  logic [NCF-1:0] ecf_q;
  logic [NPG-1:0] epg_q;
  logic [NPF-1:0] epf_q;
  logic           cpu_tick, cpu_nxt, cpu_rise, pci_nxt;

  assign ratio    = (pci_div_sel == 2'd0) ? 3'd2 : (pci_div_sel == 2'd1) ? 3'd3 : 3'd4;
  assign hi_lim   = ratio >> 1;
  assign cpu_tick = (div_cnt == CW'(CPU_HALF - 1));
  assign cpu_nxt  = cpu_raw ^ cpu_tick;
  assign cpu_rise = cpu_tick & ~cpu_raw;

  always_comb begin
    pci_cnt_nxt = pci_cnt;
    if (cpu_rise)
      pci_cnt_nxt = ({1'b0, pci_cnt} >= ratio - 3'd1) ? 2'd0 : pci_cnt + 2'd1;
  end

  assign pci_nxt = cpu_rise ? ({1'b0, pci_cnt_nxt} < hi_lim) : pci_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      cpu_raw <= 1'b0;
      pci_cnt <= '0;
      pci_raw <= 1'b0;
      cs_sync <= 2'b11;
      ps_sync <= 2'b11;
      ecg_q   <= '0;
      ecf_q   <= '0;
      epg_q   <= '0;
      epf_q   <= '0;
    end else begin
      div_cnt <= cpu_tick ? '0 : div_cnt + CW'(1);
      cpu_raw <= cpu_nxt;
      pci_cnt <= pci_cnt_nxt;
      pci_raw <= pci_nxt;
      cs_sync <= {cs_sync[0], cpu_stop_n};
      ps_sync <= {ps_sync[0], pci_stop_n};
      if (!cpu_nxt) begin
        ecg_q <= en_cg & {NCG{cs_sync[1]}};
        ecf_q <= en_cf;
      end
      if (!pci_nxt) begin
        epg_q <= en_pg & {NPG{ps_sync[1]}};
        epf_q <= en_pf;
      end
    end
  end

  assign drv_en_o    = ~hiz_i;
  assign cpu_gated_o = ecg_q & {NCG{cpu_raw & ~hiz_i}};
  assign cpu_free_o  = ecf_q & {NCF{cpu_raw & ~hiz_i}};
  assign pci_gated_o = epg_q & {NPG{pci_raw & ~hiz_i}};
  assign pci_free_o  = epf_q & {NPF{pci_raw & ~hiz_i}};
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
  parameter int NCG = 6,
  parameter int NPG = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hiz_i,
  input logic           cpu_raw,
  input logic           pci_raw,
  input logic           cs_s,
  input logic           ps_s,
  input logic [NCG-1:0] cpu_gated_o,
  input logic [NPG-1:0] pci_gated_o,
  input logic           drv_en_o
);
  a_r6_cpu_rise_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (!hiz_i && $past(!hiz_i) && |(cpu_gated_o & ~$past(cpu_gated_o))) |-> $rose(cpu_raw));

  a_r6_pci_rise_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (!hiz_i && $past(!hiz_i) && |(pci_gated_o & ~$past(pci_gated_o))) |-> $rose(pci_raw));

  a_r3_pci_edge_on_cpu_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pci_raw) || $fell(pci_raw)) |-> $rose(cpu_raw));

  a_r5_cpu_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cs_s) && !cs_s && !cpu_raw) |=> (cpu_gated_o == '0));

  a_r7_pci_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!ps_s) && !ps_s && !pci_raw) |=> (pci_gated_o == '0));

  a_r10_hiz_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_i |-> (cpu_gated_o == '0 && pci_gated_o == '0 && !drv_en_o));
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.NCG(NCG), .NPG(NPG)) chk_i (
  .clk(clk), .rst_n(rst_n), .hiz_i(hiz_i), .cpu_raw(cpu_raw), .pci_raw(pci_raw),
  .cs_s(cs_sync[1]), .ps_s(ps_sync[1]), .cpu_gated_o(cpu_gated_o),
  .pci_gated_o(pci_gated_o), .drv_en_o(drv_en_o)
);

// File: tb/clkstop_ctrl_tb_top.sv
module clkstop_ctrl_tb_top;
  localparam int CH = 2, NCG = 6, NCF = 3, NPG = 5, NPF = 2;
  localparam int CPER = 2 * CH;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, hiz_i = 1'b0;
  logic [1:0] pci_div_sel = 2'd0;
  logic [NCG-1:0] en_cg = '1;
  logic [NCF-1:0] en_cf = '1;
  logic [NPG-1:0] en_pg = '1;
  logic [NPF-1:0] en_pf = '1;
  logic [NCG-1:0] cpu_gated_o;
  logic [NCF-1:0] cpu_free_o;
  logic [NPG-1:0] pci_gated_o;
  logic [NPF-1:0] pci_free_o;
  logic drv_en_o;

  clkstop_ctrl #(.CPU_HALF(CH), .NCG(NCG), .NCF(NCF), .NPG(NPG), .NPF(NPF)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .pci_div_sel(pci_div_sel), .en_cg(en_cg), .en_cf(en_cf), .en_pg(en_pg), .en_pf(en_pf),
    .hiz_i(hiz_i), .cpu_gated_o(cpu_gated_o), .cpu_free_o(cpu_free_o),
    .pci_gated_o(pci_gated_o), .pci_free_o(pci_free_o), .drv_en_o(drv_en_o));

  int errs = 0, checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // behavioural reference model
  int m_cnt, m_pcnt, m_r, m_pc;
  bit m_cpu, m_pci, m_tk, m_cn, m_rs, m_pn;
  bit [1:0] m_cs, m_ps;
  logic [NCG-1:0] m_ecg;
  logic [NCF-1:0] m_ecf;
  logic [NPG-1:0] m_epg;
  logic [NPF-1:0] m_epf;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pcnt = 0; m_cpu = 0; m_pci = 0; m_cs = 2'b11; m_ps = 2'b11;
      m_ecg = '0; m_ecf = '0; m_epg = '0; m_epf = '0;
    end else begin
      m_r  = (pci_div_sel == 0) ? 2 : (pci_div_sel == 1) ? 3 : 4;
      m_tk = (m_cnt == CH - 1);
      m_cn = m_tk ? !m_cpu : m_cpu;
      m_rs = m_tk && !m_cpu;
      m_pc = m_pcnt;
      if (m_rs) m_pc = (m_pcnt >= m_r - 1) ? 0 : m_pcnt + 1;
      m_pn = m_rs ? (m_pc < m_r / 2) : m_pci;
      if (!m_cn) begin m_ecg = m_cs[1] ? en_cg : '0; m_ecf = en_cf; end
      if (!m_pn) begin m_epg = m_ps[1] ? en_pg : '0; m_epf = en_pf; end
      m_cs = {m_cs[0], cpu_stop_n};
      m_ps = {m_ps[0], pci_stop_n};
      m_cnt = m_tk ? 0 : m_cnt + 1;
      m_cpu = m_cn; m_pci = m_pn; m_pcnt = m_pc;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(cpu_gated_o == (hiz_i ? '0 : (m_cpu ? m_ecg : '0)), "R4 R6 model cpu_gated",
          int'(cpu_gated_o), int'(m_cpu ? m_ecg : '0));
      chk(cpu_free_o == (hiz_i ? '0 : (m_cpu ? m_ecf : '0)), "R2 R8 model cpu_free",
          int'(cpu_free_o), int'(m_cpu ? m_ecf : '0));
      chk(pci_gated_o == (hiz_i ? '0 : (m_pci ? m_epg : '0)), "R4 R6 model pci_gated",
          int'(pci_gated_o), int'(m_pci ? m_epg : '0));
      chk(pci_free_o == (hiz_i ? '0 : (m_pci ? m_epf : '0)), "R3 R8 model pci_free",
          int'(pci_free_o), int'(m_pci ? m_epf : '0));
    end
  end

  function automatic bit sigv(input int w);
    case (w)
      0: return cpu_free_o[0];
      1: return pci_free_o[0];
      2: return cpu_gated_o[0];
      default: return pci_gated_o[0];
    endcase
  endfunction

  task automatic meas(input int w, output int per, output int hi);
    bit prev;
    int n;
    per = 0; hi = 0; n = 0;
    prev = sigv(w);
    while (!( !prev && sigv(w)) && n < 300) begin prev = sigv(w); @(negedge clk); n++; end
    while (sigv(w) && n < 300) begin hi++; per++; @(negedge clk); n++; end
    while (!sigv(w) && n < 300) begin per++; @(negedge clk); n++; end
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int per, hi, lat, togs, ptogs, r;
    bit prev, pprev;
    repeat (3) @(negedge clk);
    // R1
    chk(cpu_gated_o == '0 && cpu_free_o == '0 && pci_gated_o == '0 && pci_free_o == '0,
        "R1 outputs in reset", int'(cpu_free_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_gated_o == '0 && cpu_free_o == '0 && pci_gated_o == '0 && pci_free_o == '0,
        "R1 first cycle after reset", int'(cpu_free_o), 0);
    chk(drv_en_o == 1'b1, "R10 drv_en with hiz low", int'(drv_en_o), 1);
    repeat (10) @(negedge clk);

    // R2
    meas(0, per, hi);
    chk(per == CPER, "R2 cpu period", per, CPER);
    chk(hi == CH, "R2 cpu high time", hi, CH);

    // R3 ratio sweep
    for (int s = 0; s < 4; s++) begin
      pci_div_sel = 2'(s);
      r = (s == 0) ? 2 : (s == 1) ? 3 : 4;
      repeat (40) @(negedge clk);
      meas(1, per, hi);
      chk(per == CPER * r, "R3 pci period", per, CPER * r);
      chk(hi == CPER * (r / 2), "R3 pci high time", hi, CPER * (r / 2));
    end

    // R5, R8: CPU stop
    pci_div_sel = 2'd0;
    repeat (20) @(negedge clk);
    cpu_stop_n = 1'b0;
    lat = 0; togs = 0; ptogs = 0;
    prev = cpu_free_o[0]; pprev = pci_gated_o[0];
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (cpu_gated_o != '0) lat = i;
      if (cpu_free_o[0] != prev) togs++;
      if (pci_gated_o[0] != pprev) ptogs++;
      prev = cpu_free_o[0]; pprev = pci_gated_o[0];
    end
    chk(lat < 4 * CPER, "R5 cpu stop latency", lat, 4 * CPER);
    chk(cpu_gated_o == '0, "R5 cpu gated at rest", int'(cpu_gated_o), 0);
    chk(togs > 10, "R8 cpu free runs under cpu stop", togs, 11);
    chk(ptogs > 4, "R8 pci gated runs under cpu stop", ptogs, 5);
    cpu_stop_n = 1'b1;
    lat = 0;
    while (!cpu_gated_o[0] && lat < 100) begin @(negedge clk); lat++; end
    chk(lat < 4 * CPER, "R5 cpu restart latency", lat, 4 * CPER);
    hi = 0;
    while (cpu_gated_o[0] && hi < 100) begin @(negedge clk); hi++; end
    chk(hi == CH, "R6 first cpu pulse full width", hi, CH);

    // R7, R8: PCI stop
    pci_div_sel = 2'd2;
    repeat (40) @(negedge clk);
    @(negedge clk);
    pci_stop_n = 1'b0;
    lat = 0; togs = 0; ptogs = 0;
    prev = cpu_gated_o[0]; pprev = pci_free_o[0];
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (pci_gated_o != '0) lat = i;
      if (cpu_gated_o[0] != prev) togs++;
      if (pci_free_o[0] != pprev) ptogs++;
      prev = cpu_gated_o[0]; pprev = pci_free_o[0];
    end
    chk(lat <= CPER * 4 + 3, "R7 pci stop latency", lat, CPER * 4 + 3);
    chk(pci_gated_o == '0, "R7 pci gated at rest", int'(pci_gated_o), 0);
    chk(togs > 10, "R8 cpu gated runs under pci stop", togs, 11);
    chk(ptogs > 3, "R8 pci free runs under pci stop", ptogs, 4);
    pci_stop_n = 1'b1;
    lat = 0;
    while (!pci_gated_o[0] && lat < 100) begin @(negedge clk); lat++; end
    chk(lat <= CPER * 4 + 3, "R7 pci restart latency", lat, CPER * 4 + 3);
    hi = 0;
    while (pci_gated_o[0] && hi < 100) begin @(negedge clk); hi++; end
    chk(hi == CPER * 2, "R6 first pci pulse full width", hi, CPER * 2);

    // R9 enables
    en_cf = '0; en_pf = '0; en_cg = 6'b111101;
    repeat (40) @(negedge clk);
    togs = 0; ptogs = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (cpu_free_o != '0 || pci_free_o != '0) togs++;
      if (cpu_gated_o[1]) ptogs++;
    end
    chk(togs == 0, "R9 free outputs silenced", togs, 0);
    chk(ptogs == 0, "R9 single gated bit silenced", ptogs, 0);
    en_cf = '1; en_pf = '1; en_cg = '1;
    meas(0, per, hi);
    chk(hi == CH, "R9 re-enabled cpu free first pulse", hi, CH);
    meas(1, per, hi);
    chk(hi == CPER * 2, "R9 re-enabled pci free first pulse", hi, CPER * 2);

    // R10 hiz
    hiz_i = 1'b1;
    togs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cpu_gated_o != '0 || cpu_free_o != '0 || pci_gated_o != '0 ||
          pci_free_o != '0 || drv_en_o) togs++;
    end
    chk(togs == 0, "R10 outputs quiet under hiz", togs, 0);
    hiz_i = 1'b0;
    @(negedge clk);
    chk(drv_en_o == 1'b1, "R10 drv_en restored", int'(drv_en_o), 1);
    repeat (40) @(negedge clk);
    finish_up();
  end
endmodule